// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative translation buffer for 32-bit virtual addresses. Each of its entries covers two neighbouring virtual pages, an even one and an odd one. Each half has its own physical frame number, its own valid bit and its own dirty (writable) bit. An entry also carries a page-size mask, an 8-bit address-space tag and a global flag. Translations for several address spaces can therefore coexist, and a global entry serves all of them.

A lookup presents a virtual address, a write flag and the current address-space tag. One clock later the block returns the physical address, read and write permission bits and a small signed result code. The code tells a successful translation apart from three faults: no entry matched, the selected half is not valid, and a write hit a clean page. Software or a refill engine loads entries through an indexed write port. The lookup itself is combinational over the stored entries, and only the response is registered.

Top module: `ptlb_lookup`

## Requirements
- R1: An entry matches when its global flag is set or its stored tag equals `req_asid`, and its stored virtual tag equals `req_va` on every bit above the effective mask.
- R2: The effective mask is the entry's `wr_pmask` value ORed with 0x1FFF. The smallest page pair is therefore 8 KB (4 KB halves), and a mask of 0x1E000 gives 64 KB halves.
- R3: The half is chosen by the highest set bit of the effective mask. When that bit of the address is 0 the even fields are used, and when it is 1 the odd fields are used.
- R4: On a match whose chosen half has its valid bit clear, the code is INVALID (3'b101), with the address and both permissions zero.
- R5: On a match with the half valid, a write to a half whose dirty bit is clear gives DIRTY (3'b100). A read of a valid half always succeeds.
- R6: On success the code is MATCH (3'b000). `rsp_pa` is the half's frame number shifted left by 12, ORed with the address bits under the half-page offset mask (effective mask shifted right by one). `rsp_rd_ok` is 1, and `rsp_wr_ok` equals the half's dirty bit.
- R7: When no entry matches, the code is NOMATCH (3'b110). Codes are 3-bit two's complement values of 0, -2, -3 and -4. BADADDR (3'b111) is never produced.
- R8: When several entries match, the one with the lowest index decides the result.
- R9: `rsp_valid` is high in the cycle after an edge at which `req_valid` was high. In all other cycles `rsp_valid`, `rsp_pa`, `rsp_code`, `rsp_rd_ok` and `rsp_wr_ok` are all zero.
- R10: A write strobed at an edge is seen by lookups sampled at the following edge, but not by a lookup sampled at the same edge. Reset clears every field of every entry to zero. A reset table therefore answers INVALID for tag 0 in the page pair at address 0, and NOMATCH for any other tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load strobe for the entry at `wr_idx` |
| wr_idx | input | 4 | Entry index to load |
| wr_vtag | input | 32 | Virtual tag (pair base address) |
| wr_pmask | input | 32 | Page-size mask, contiguous ones from bit 13 upward |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_global | input | 1 | Entry matches every address space |
| wr_pfn_even | input | 20 | Frame number of the even half |
| wr_val_even | input | 1 | Even half valid |
| wr_dty_even | input | 1 | Even half writable |
| wr_pfn_odd | input | 20 | Frame number of the odd half |
| wr_val_odd | input | 1 | Odd half valid |
| wr_dty_odd | input | 1 | Odd half writable |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_asid | input | 8 | Current address-space tag |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 32 | Translated physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_code | output | 3 | Result code (two's complement) |

## Verification
The bench aims at the choice of half. An address whose select bit depends on the page mask is looked up under 8 KB and 128 KB pairs, so a design that always used bit 12 would return the wrong frame for large pages. Two entries are loaded with the same tag to check that the lowest index wins. A design that scanned from the top would return the other frame. A load and a lookup of the same page in one cycle expose a write that bypasses the entry store too early. Clean-page writes, invalid halves and a foreign tag against a private or a global entry separate the three fault codes. Any mix-up among them shows up as a wrong code.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int PAGE_SHIFT = 12;
    localparam int PAIR_SHIFT = PAGE_SHIFT + 1;
    localparam int PFN_W      = PA_W - PAGE_SHIFT;
    localparam logic [VA_W-1:0] PAIR_LOW = VA_W'((64'd1 << PAIR_SHIFT) - 64'd1);

    localparam logic [2:0] RC_MATCH   = 3'b000;
    localparam logic [2:0] RC_BADADDR = 3'b111;
    localparam logic [2:0] RC_NOMATCH = 3'b110;
    localparam logic [2:0] RC_INVALID = 3'b101;
    localparam logic [2:0] RC_DIRTY   = 3'b100;

    typedef struct packed {
        logic [VA_W-1:0]   vtag;
        logic [VA_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn_e;
        logic [PFN_W-1:0]  pfn_o;
        logic              val_e;
        logic              val_o;
        logic              dty_e;
        logic              dty_o;
    } entry_t;
endpackage

// File: rtl/ptlb_entry_cmp.sv
module ptlb_entry_cmp
    import ptlb_pkg::*;
(
    input  entry_t            ent,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic              odd,
    output logic [VA_W-1:0]   off_mask
);
    logic [VA_W-1:0] eff;
    logic [VA_W-1:0] sel_bit;

    always_comb begin
        eff      = ent.pmask | PAIR_LOW;
        off_mask = eff >> 1;
        sel_bit  = eff & ~off_mask;
        odd      = |(va & sel_bit);
        hit      = (ent.glob || (ent.asid == asid)) &&
                   ((ent.vtag & ~eff) == (va & ~eff));
    end
endmodule

// File: rtl/ptlb_prio.sv
module ptlb_prio #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ptlb_lookup.sv
module ptlb_lookup
    import ptlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_vtag,
    input  logic [VA_W-1:0]   wr_pmask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_val_even,
    input  logic              wr_dty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_val_odd,
    input  logic              wr_dty_odd,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_rd_ok,
    output logic              rsp_wr_ok,
    output logic [2:0]        rsp_code
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
        logic                 rv;
        logic [PA_W-1:0]      pa;
        logic                 rd;
        logic                 wr;
        logic [2:0]           code;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] odd_vec;
    logic [VA_W-1:0]    offm [ENTRIES];
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        ptlb_entry_cmp u_cmp (
            .ent      (st_q.tbl[g]),
            .va       (req_va),
            .asid     (req_asid),
            .hit      (hit_vec[g]),
            .odd      (odd_vec[g]),
            .off_mask (offm[g])
        );
    end

    ptlb_prio #(.N(ENTRIES)) u_prio (
        .req (hit_vec),
        .any (any_hit),
        .idx (win_idx)
    );

    entry_t           sel;
    logic             h_odd;
    logic             h_val;
    logic             h_dty;
    logic [PFN_W-1:0] h_pfn;
    logic [VA_W-1:0]  h_off;

    always_comb begin
        st_d  = st_q;
        sel   = st_q.tbl[win_idx];
        h_odd = odd_vec[win_idx];
        h_off = offm[win_idx];
        h_val = h_odd ? sel.val_o : sel.val_e;
        h_dty = h_odd ? sel.dty_o : sel.dty_e;
        h_pfn = h_odd ? sel.pfn_o : sel.pfn_e;

        st_d.rv   = req_valid;
        st_d.pa   = '0;
        st_d.rd   = 1'b0;
        st_d.wr   = 1'b0;
        st_d.code = RC_MATCH;
        if (req_valid) begin
            if (!any_hit) begin
                st_d.code = RC_NOMATCH;
            end else if (!h_val) begin
                st_d.code = RC_INVALID;
            end else if (req_write && !h_dty) begin
                st_d.code = RC_DIRTY;
            end else begin
                st_d.code = RC_MATCH;
                st_d.pa   = {h_pfn, {PAGE_SHIFT{1'b0}}} | PA_W'(req_va & h_off);
                st_d.rd   = 1'b1;
                st_d.wr   = h_dty;
            end
        end

        if (wr_en) begin
            st_d.tbl[wr_idx].vtag  = wr_vtag;
            st_d.tbl[wr_idx].pmask = wr_pmask;
            st_d.tbl[wr_idx].asid  = wr_asid;
            st_d.tbl[wr_idx].glob  = wr_global;
            st_d.tbl[wr_idx].pfn_e = wr_pfn_even;
            st_d.tbl[wr_idx].val_e = wr_val_even;
            st_d.tbl[wr_idx].dty_e = wr_dty_even;
            st_d.tbl[wr_idx].pfn_o = wr_pfn_odd;
            st_d.tbl[wr_idx].val_o = wr_val_odd;
            st_d.tbl[wr_idx].dty_o = wr_dty_odd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rv;
    assign rsp_pa    = st_q.pa;
    assign rsp_rd_ok = st_q.rd;
    assign rsp_wr_ok = st_q.wr;
    assign rsp_code  = st_q.code;
endmodule

module ptlb_lookup_chk
    import ptlb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_rd_ok,
    input logic            rsp_wr_ok,
    input logic [2:0]      rsp_code
);
    a_r9_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_code == 3'b000 && !rsp_rd_ok && !rsp_wr_ok && rsp_pa == '0));
    a_r6_write_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ok |-> (rsp_rd_ok && rsp_code == RC_MATCH));
    a_r6_match_grants_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_MATCH) |-> rsp_rd_ok);
    a_r5_dirty_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_DIRTY) |-> $past(req_write));
    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != RC_BADADDR && rsp_code != 3'b001 &&
                       rsp_code != 3'b010 && rsp_code != 3'b011));
endmodule

bind ptlb_lookup ptlb_lookup_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_pa    (rsp_pa),
    .rsp_rd_ok (rsp_rd_ok),
    .rsp_wr_ok (rsp_wr_ok),
    .rsp_code  (rsp_code)
);

// File: tb/ptlb_lookup_tb_top.sv
`timescale 1ns/1ps
module ptlb_lookup_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_vtag = '0, wr_pmask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
    logic        wr_val_even = 1'b0, wr_dty_even = 1'b0, wr_val_odd = 1'b0, wr_dty_odd = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic        rsp_valid, rsp_rd_ok, rsp_wr_ok;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_code;

    always #2 clk = ~clk;

    ptlb_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vtag(wr_vtag),
        .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_pfn_even(wr_pfn_even), .wr_val_even(wr_val_even), .wr_dty_even(wr_dty_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_val_odd(wr_val_odd), .wr_dty_odd(wr_dty_odd),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_asid(req_asid),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_rd_ok(rsp_rd_ok),
        .rsp_wr_ok(rsp_wr_ok), .rsp_code(rsp_code)
    );

    // behavioural table model
    logic [31:0] m_vtag [16];
    logic [31:0] m_pm   [16];
    logic [7:0]  m_asid [16];
    logic [19:0] m_pe   [16];
    logic [19:0] m_po   [16];
    bit          m_g [16], m_ve [16], m_de [16], m_vo [16], m_do [16];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic load(input int idx, input logic [31:0] vt, input logic [31:0] pm,
                        input logic [7:0] as, input bit g,
                        input logic [19:0] pe, input bit ve, input bit de,
                        input logic [19:0] po, input bit vo, input bit dd);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vtag = vt; wr_pmask = pm; wr_asid = as;
        wr_global = g; wr_pfn_even = pe; wr_val_even = ve; wr_dty_even = de;
        wr_pfn_odd = po; wr_val_odd = vo; wr_dty_odd = dd;
    endtask

    task automatic look(input logic [31:0] va, input bit w, input logic [7:0] as);
        req_valid = 1'b1; req_va = va; req_write = w; req_asid = as;
    endtask

    // one clock: predict, apply write to model, advance, compare
    task automatic cyc(input string tag);
        logic [31:0] e_pa;
        logic [2:0]  e_code;
        bit e_rv, e_rd, e_wr;
        int found;
        e_rv = req_valid; e_pa = '0; e_code = 3'b000; e_rd = 1'b0; e_wr = 1'b0;
        if (req_valid) begin
            found = -1;
            for (int i = 0; i < 16; i++) begin
                logic [31:0] eff;
                eff = m_pm[i] | 32'h1FFF;
                if (found < 0 && (m_g[i] || m_asid[i] == req_asid) &&
                    (((m_vtag[i] ^ req_va) & ~eff) == 32'h0))
                    found = i;
            end
            if (found < 0) e_code = 3'b110;
            else begin
                logic [31:0] eff, half;
                bit o, v, d;
                logic [19:0] pf;
                eff = m_pm[found] | 32'h1FFF;
                half = eff >> 1;
                o = ((req_va & (eff & ~half)) != 0);
                v = o ? m_vo[found] : m_ve[found];
                d = o ? m_do[found] : m_de[found];
                pf = o ? m_po[found] : m_pe[found];
                if (!v) e_code = 3'b101;
                else if (req_write && !d) e_code = 3'b100;
                else begin
                    e_pa = {pf, 12'h000} | (req_va & half);
                    e_rd = 1'b1; e_wr = d;
                end
            end
        end
        if (wr_en) begin
            m_vtag[wr_idx] = wr_vtag; m_pm[wr_idx] = wr_pmask; m_asid[wr_idx] = wr_asid;
            m_g[wr_idx] = wr_global; m_pe[wr_idx] = wr_pfn_even; m_ve[wr_idx] = wr_val_even;
            m_de[wr_idx] = wr_dty_even; m_po[wr_idx] = wr_pfn_odd; m_vo[wr_idx] = wr_val_odd;
            m_do[wr_idx] = wr_dty_odd;
        end
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== e_rv || rsp_code !== e_code || rsp_pa !== e_pa ||
            rsp_rd_ok !== e_rd || rsp_wr_ok !== e_wr) begin
            n_fail++;
            $display("FAIL %s: got v=%0b code=%b pa=%h rd=%0b wr=%0b, expected v=%0b code=%b pa=%h rd=%0b wr=%0b",
                     tag, rsp_valid, rsp_code, rsp_pa, rsp_rd_ok, rsp_wr_ok,
                     e_rv, e_code, e_pa, e_rd, e_wr);
        end
        wr_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected finish within limit");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_vtag[i] = '0; m_pm[i] = '0; m_asid[i] = '0; m_pe[i] = '0; m_po[i] = '0;
            m_g[i] = 0; m_ve[i] = 0; m_de[i] = 0; m_vo[i] = 0; m_do[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc("R9 reset idle outputs zero");
        look(32'h0000_3000, 0, 8'd7); cyc("R7 R10 reset table foreign tag nomatch");
        look(32'h0000_1000, 0, 8'd0); cyc("R10 reset table tag 0 invalid");

        load(3, 32'h0040_0000, 32'h0, 8'd5, 0, 20'h12345, 1, 1, 20'h54321, 1, 0);
        look(32'h0040_0123, 0, 8'd5); cyc("R10 same-cycle write not visible");
        look(32'h0040_0123, 0, 8'd5); cyc("R6 even read after load");
        look(32'h0040_1ABC, 0, 8'd5); cyc("R3 R6 odd read clean page");
        look(32'h0040_1ABC, 1, 8'd5); cyc("R5 odd write clean -> dirty fault");
        look(32'h0040_0FF0, 1, 8'd5); cyc("R5 even write dirty page ok");
        look(32'h0040_0123, 0, 8'd6); cyc("R1 foreign tag nomatch");
        cyc("R9 idle after traffic");

        load(5, 32'h1000_0000, 32'h0, 8'd9, 1, 20'h0AAAA, 0, 0, 20'h0BBBB, 1, 1);
        cyc("R10 load global entry");
        look(32'h1000_0004, 0, 8'd2); cyc("R1 R4 global even half invalid");
        look(32'h1000_1008, 1, 8'd2); cyc("R1 R6 global odd write ok");

        load(7, 32'h0200_0000, 32'h0001_E000, 8'd5, 0, 20'h80000, 1, 0, 20'h90000, 1, 1);
        cyc("R10 load large page");
        look(32'h0200_F123, 0, 8'd5); cyc("R2 R3 large page even half");
        look(32'h0201_0456, 0, 8'd5); cyc("R2 R3 large page odd half");
        look(32'h0203_0000, 0, 8'd5); cyc("R2 outside large pair nomatch");

        load(9, 32'h0500_0000, 32'h0, 8'd1, 0, 20'h11111, 1, 1, 20'h11112, 1, 1);
        cyc("R8 load low entry");
        load(12, 32'h0500_0000, 32'h0, 8'd1, 0, 20'h22222, 1, 1, 20'h22223, 1, 1);
        cyc("R8 load high entry");
        look(32'h0500_0ABC, 0, 8'd1); cyc("R8 lowest index wins");
        load(9, 32'h0600_0000, 32'h0, 8'd1, 0, 20'h11111, 1, 1, 20'h11112, 1, 1);
        look(32'h0500_0ABC, 0, 8'd1); cyc("R8 R10 low entry still used same cycle");
        look(32'h0500_0ABC, 0, 8'd1); cyc("R8 high entry wins after move");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] bases [5];
            logic [31:0] pms [3];
            bases = '{32'h0040_0000, 32'h1000_0000, 32'h0200_0000, 32'h0500_0000, 32'h0600_0000};
            pms = '{32'h0, 32'h0000_6000, 32'h0001_E000};
            if ($urandom_range(0, 4) == 0)
                load($urandom_range(0, 15), bases[$urandom_range(0, 4)], pms[$urandom_range(0, 2)],
                     8'($urandom_range(0, 5)), bit'($urandom_range(0, 1)),
                     20'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                     20'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) != 0)
                look(bases[$urandom_range(0, 4)] | ($urandom & 32'h0001_FFFF),
                     bit'($urandom_range(0, 1)), 8'($urandom_range(0, 5)));
            cyc("R1 R3 R5 R7 R8 R9 random mix");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule